// File: doc/BRIEF.md
# Page Write Buffer with Busy Polling

This block sits between a two-wire serial protocol engine and a byte-wide storage array. The engine hands over a word-address load when the addressing phase of a write ends. It then passes each received data byte as a one-cycle strobe, and it reports the bus stop condition as another one-cycle strobe. The block keeps the word address counter. Incoming bytes go into a page buffer of `PAGE_BYTES` slots. Only the low in-page bits of the address advance from byte to byte, so a burst longer than one page wraps around and overwrites bytes buffered earlier.

When the stop condition arrives after at least one data byte, the block starts a self-timed commit. It visits every slot of the page once per clock and writes to the array only the slots that received data. It then waits `CYCLE_CLKS` further clocks, which stand for the nonvolatile programming time. `busy` is high for the whole commit. The protocol engine uses it to withhold every acknowledge, so a master that keeps repeating its addressing byte sees an acknowledge only after the commit ends. While `busy` is high, every input strobe is ignored. A high level on the write-protect input at the stop condition throws the buffered page away instead of committing it. Reads, which step the address counter, are not affected by write protect.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy` is 0, `next_addr` is 0 and `arr_we` is 0.
- R2: Each accepted `byte_vld` stores `byte_data` in the buffer at the current word address. After the store, only the low log2(`PAGE_BYTES`) bits of `next_addr` increment, wrapping within the page, and the upper bits stay fixed. A later byte to the same slot replaces the earlier one.
- R3: A `stop_seen` pulse while idle, with at least one byte buffered and `wr_protect` low, raises `busy` on the next cycle. During the commit, the array receives exactly one write for each buffered slot. The write goes to address {page bits of the last byte written, slot} and carries the last byte given to that slot. Array locations with no buffered byte are not written.
- R4: `busy` stays high for exactly `PAGE_BYTES` + `CYCLE_CLKS` consecutive cycles, and `arr_we` is asserted only while `busy` is high.
- R5: While `busy` is high, `byte_vld`, `addr_load`, `read_step` and `stop_seen` have no effect. Neither `next_addr`, the array, nor the buffer contents seen at the next stop change because of them.
- R6: A `stop_seen` pulse with no byte buffered (for example after an address-only dummy write) leaves `busy` at 0, writes nothing and leaves `next_addr` unchanged.
- R7: A `stop_seen` pulse with `wr_protect` high writes nothing to the array, leaves `busy` at 0 and discards the buffered bytes.
- R8: A `stop_seen` pulse with at least one byte buffered sets `next_addr` to the address of the last byte written plus one, modulo 2^`ADDR_W`. This holds whether or not write protect is active.
- R9: An accepted `read_step` increments `next_addr` by one over the full address width, wrapping from all-ones to 0, whatever the level of `wr_protect`.
- R10: An accepted `addr_load` sets `next_addr` to `addr_value` and discards any bytes not yet committed. In one cycle, the strobes take priority in the order `stop_seen`, `addr_load`, `byte_vld`, `read_step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_protect | input | 1 | High blocks commits to the array |
| addr_load | input | 1 | Load word address strobe |
| addr_value | input | ADDR_W | Word address to load |
| byte_vld | input | 1 | Data byte received strobe |
| byte_data | input | DATA_W | Received data byte |
| stop_seen | input | 1 | Bus stop condition strobe |
| read_step | input | 1 | A byte was read; advance address |
| busy | output | 1 | Commit in progress; withhold acknowledges |
| next_addr | output | ADDR_W | Current word address counter |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The hardest state to reach is a commit window in which every input strobe arrives while `busy` is high. The bench launches a commit and then pulses each strobe in turn, a stray stop included, inside the window. After the window it shows that the address counter, the array image and a following empty stop all behave as if nothing had arrived. Page wrap with overwriting needs more than a page of bytes starting near the page end. Directed bursts start two slots before the boundary, and random bursts of up to one and a half pages from random addresses cover the other offsets. Every commit is compared against a full shadow image of the array.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef enum logic [1:0] {
        PCB_IDLE  = 2'd0,
        PCB_WRITE = 2'd1,
        PCB_WAIT  = 2'd2
    } pcb_state_e;

    typedef struct packed {
        logic        ld;
        logic        step_page;
        logic        step_full;
    } pcb_addr_op_t;

    // advance only the low lo_bits of a, leaving upper bits fixed
    function automatic logic [15:0] pcb_low_inc(input logic [15:0] a, input int unsigned lo_bits);
        logic [15:0] mask;
        mask = (16'd1 << lo_bits) - 16'd1;
        return (a & ~mask) | ((a + 16'd1) & mask);
    endfunction

endpackage

// File: rtl/pcb_page_buf.sv
module pcb_page_buf #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int PTR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                valid_q[s] <= 1'b0;
                data_q[s]  <= '0;
            end else if (wr_en && (wr_slot == PTR_W'(s))) begin
                valid_q[s] <= 1'b1;
                data_q[s]  <= wr_data;
            end
        end
    end

    assign rd_data   = data_q[rd_slot];
    assign rd_valid  = valid_q[rd_slot];
    assign any_valid = |valid_q;
endmodule

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr
    import pcb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  pcb_addr_op_t      op,
    input  logic [ADDR_W-1:0] ld_value,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (op.ld)
            addr <= ld_value;
        else if (op.step_page)
            addr <= ADDR_W'(pcb_low_inc(16'(addr), PTR_W));
        else if (op.step_full)
            addr <= addr + 1'b1;
    end
endmodule

// File: rtl/pcb_cycle_timer.sv
module pcb_cycle_timer #(
    parameter int LIMIT = 40,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int CYCLE_CLKS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_protect,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_seen,
    input  logic              read_step,
    output logic              busy,
    output logic [ADDR_W-1:0] next_addr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int PTR_W = $clog2(PAGE_BYTES);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(PAGE_BYTES - 1);

    pcb_state_e        state_q;
    logic [PTR_W-1:0]  slot_q;
    logic [ADDR_W-1:0] last_wr_q;
    logic              idle, have_data, commit_go, write_last, timer_done;
    logic              buf_clr, slot_valid;
    logic [DATA_W-1:0] slot_data;
    pcb_addr_op_t      aop;
    logic [ADDR_W-1:0] ld_value;

    assign idle       = (state_q == PCB_IDLE);
    assign busy       = !idle;
    assign commit_go  = idle && stop_seen && have_data && !wr_protect;
    assign write_last = (state_q == PCB_WRITE) && (slot_q == LAST_SLOT);

    // strobe priority: stop, address load, data byte, read step
    always_comb begin
        aop.ld        = idle && ((stop_seen && have_data) || (!stop_seen && addr_load));
        aop.step_page = idle && !stop_seen && !addr_load && byte_vld;
        aop.step_full = idle && !stop_seen && !addr_load && !byte_vld && read_step;
        ld_value      = stop_seen ? last_wr_q + 1'b1 : addr_value;
    end

    assign buf_clr = (idle && (addr_load || stop_seen) && !commit_go) || write_last;

    pcb_addr_ctr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .op       (aop),
        .ld_value (ld_value),
        .addr     (next_addr)
    );

    pcb_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .wr_en     (aop.step_page),
        .wr_slot   (next_addr[PTR_W-1:0]),
        .wr_data   (byte_data),
        .rd_slot   (slot_q),
        .rd_data   (slot_data),
        .rd_valid  (slot_valid),
        .any_valid (have_data)
    );

    pcb_cycle_timer #(.LIMIT(CYCLE_CLKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == PCB_WAIT),
        .expired (timer_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PCB_IDLE;
            slot_q    <= '0;
            last_wr_q <= '0;
        end else begin
            if (aop.step_page)
                last_wr_q <= next_addr;
            unique case (state_q)
                PCB_IDLE: begin
                    slot_q <= '0;
                    if (commit_go)
                        state_q <= PCB_WRITE;
                end
                PCB_WRITE: begin
                    slot_q <= slot_q + 1'b1;
                    if (write_last)
                        state_q <= PCB_WAIT;
                end
                PCB_WAIT: begin
                    if (timer_done)
                        state_q <= PCB_IDLE;
                end
                default: state_q <= PCB_IDLE;
            endcase
        end
    end

    assign arr_we    = (state_q == PCB_WRITE) && slot_valid;
    assign arr_addr  = {last_wr_q[ADDR_W-1:PTR_W], slot_q};
    assign arr_wdata = slot_data;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int ADDR_W = 8,
    parameter int TOTAL  = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              stop_seen,
    input logic              addr_load,
    input logic              byte_vld,
    input logic              read_step,
    input logic [ADDR_W-1:0] next_addr,
    input logic              arr_we
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            run_q <= '0;
        else
            run_q <= run_q + 1;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == TOTAL);

    // R4
    we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    // R3
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_seen));

    // R5
    addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(next_addr));

    // R9
    read_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && read_step && !stop_seen && !addr_load && !byte_vld)
        |=> next_addr == ADDR_W'($past(next_addr) + 1'b1));
endmodule

bind page_commit_buffer pcb_checker #(
    .ADDR_W (ADDR_W),
    .TOTAL  (PAGE_BYTES + CYCLE_CLKS)
) u_pcb_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .stop_seen (stop_seen),
    .addr_load (addr_load),
    .byte_vld  (byte_vld),
    .read_step (read_step),
    .next_addr (next_addr),
    .arr_we    (arr_we)
);

// File: tb/tb_page_commit_buffer.sv
`timescale 1ns/1ps
module tb_page_commit_buffer;
    localparam int PG  = 8;
    localparam int CYC = 40;
    localparam int BUSY_LEN = PG + CYC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_protect = 1'b0;
    logic       addr_load = 1'b0;
    logic [7:0] addr_value = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_seen = 1'b0;
    logic       read_step = 1'b0;
    logic       busy, arr_we;
    logic [7:0] next_addr, arr_addr, arr_wdata;

    int tests = 0;
    int fails = 0;

    logic [7:0] arr_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] mbuf [PG];
    logic [PG-1:0] mval;
    logic [7:0] m_addr, m_last;

    always #2 clk = ~clk;

    page_commit_buffer dut (
        .clk(clk), .rst(rst), .wr_protect(wr_protect),
        .addr_load(addr_load), .addr_value(addr_value),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .stop_seen(stop_seen), .read_step(read_step),
        .busy(busy), .next_addr(next_addr),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // bench image of the array, captured mid-cycle
    always @(negedge clk) if (!rst && arr_we) arr_mem[arr_addr] = arr_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [7:0] page_inc(input logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    task automatic set_addr(input logic [7:0] a);
        addr_load = 1'b1; addr_value = a;
        tick();
        addr_load = 1'b0;
        m_addr = a; mval = '0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        tick();
        byte_vld = 1'b0;
        mbuf[m_addr[2:0]] = d; mval[m_addr[2:0]] = 1'b1;
        m_last = m_addr; m_addr = page_inc(m_addr);
    endtask

    task automatic rd_step();
        read_step = 1'b1;
        tick();
        read_step = 1'b0;
        m_addr = m_addr + 8'd1;
    endtask

    // returns expected busy length and applies the commit to the model
    task automatic stop_pulse(output int exp_len);
        stop_seen = 1'b1;
        tick();
        stop_seen = 1'b0;
        exp_len = 0;
        if (mval != '0) begin
            m_addr = m_last + 8'd1;
            if (!wr_protect) begin
                exp_len = BUSY_LEN;
                for (int s = 0; s < PG; s++)
                    if (mval[s]) exp_mem[{m_last[7:3], 3'(s)}] = mbuf[s];
            end
        end
        mval = '0;
    endtask

    task automatic measure(input int exp_len, input string req);
        int n = 0;
        while (busy && n < 2000) begin
            n++;
            tick();
        end
        check(n == exp_len, req, n, exp_len);
    endtask

    task automatic compare_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 256; i++)
            if (arr_mem[i] !== exp_mem[i] && bad < 0) bad = i;
        check(bad < 0, req, bad < 0 ? 0 : int'(arr_mem[bad]), bad < 0 ? 0 : int'(exp_mem[bad]));
    endtask

    task automatic check_addr(input string req);
        check(next_addr == m_addr, req, next_addr, m_addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int el;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin arr_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        mval = '0; m_addr = '0; m_last = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check(busy == 1'b0 && next_addr == 8'h00 && arr_we == 1'b0, "R1", {busy, arr_we, next_addr}, 0);

        // R2 R3 R4 R8: single byte
        set_addr(8'h25);
        send_byte(8'hA5);
        check_addr("R2");
        stop_pulse(el);
        measure(el, "R4");
        compare_mem("R3");
        check_addr("R8");

        // R2: wrap inside page, later bytes overwrite slots 6 and 7
        set_addr(8'h3E);
        send_byte(8'h11);
        send_byte(8'h22);
        check_addr("R2 wrap");
        for (int k = 0; k < 8; k++) send_byte(8'h30 + 8'(k));
        stop_pulse(el);
        measure(el, "R4 wrap");
        compare_mem("R2 overwrite");
        check_addr("R8 wrap");

        // R6: dummy write
        set_addr(8'h80);
        stop_pulse(el);
        measure(el, "R6");
        check_addr("R6 addr");

        // R7 and R9: write protect
        wr_protect = 1'b1;
        set_addr(8'h50);
        send_byte(8'hEE);
        send_byte(8'hDD);
        stop_pulse(el);
        measure(el, "R7");
        compare_mem("R7 array");
        check_addr("R8 protected");
        rd_step();
        check_addr("R9 protected");
        wr_protect = 1'b0;
        stop_pulse(el);
        measure(el, "R7 discard");

        // R9: full-width wrap
        set_addr(8'hFF);
        rd_step();
        check_addr("R9 wrap");

        // R10: reload discards pending bytes
        set_addr(8'h10);
        send_byte(8'h77);
        set_addr(8'h90);
        check_addr("R10 addr");
        stop_pulse(el);
        measure(el, "R10 discard");
        compare_mem("R10 array");

        // R5: strobes during busy are ignored
        set_addr(8'hC3);
        send_byte(8'h5A);
        stop_pulse(el);
        byte_vld = 1'b1; byte_data = 8'hFF; tick(); byte_vld = 1'b0;
        addr_load = 1'b1; addr_value = 8'h01; tick(); addr_load = 1'b0;
        read_step = 1'b1; tick(); read_step = 1'b0;
        stop_seen = 1'b1; tick(); stop_seen = 1'b0;
        measure(el - 4, "R5 length");
        check_addr("R5 addr");
        stop_pulse(el);
        measure(el, "R5 buffer");
        compare_mem("R5 array");

        // random transactions
        for (int t = 0; t < 40; t++) begin
            int nb;
            wr_protect = ($urandom % 4) == 0;
            set_addr(8'($urandom));
            nb = $urandom % 13;
            for (int k = 0; k < nb; k++) send_byte(8'($urandom));
            stop_pulse(el);
            measure(el, "R3 random");
            compare_mem("R3 random");
            check_addr("R8 random");
            if ($urandom % 2) begin
                rd_step();
                check_addr("R9 random");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule